// File: doc/BRIEF.md
# Receive Descriptor-Chain DMA Engine

This block moves incoming frames from a byte stream into system memory under control of descriptors that software prepares in that memory. Each descriptor occupies eight 32-bit words, and only its first four words are used. The engine reads a descriptor, writes the frame bytes into the buffer that the descriptor points to, and then closes the descriptor with a status word. After that it moves on to the next descriptor. Software and engine pass each descriptor back and forth through an ownership bit. The engine uses a descriptor only while software has marked it as engine-owned, and it clears that mark when it closes the descriptor.

The next descriptor is found in one of two ways. When the descriptor sets its chain flag, the next address comes from the descriptor's pointer word. When the flag is clear, the next descriptor sits right after the current one in memory. If the engine meets a descriptor that software still owns, it stops accepting frame bytes, raises a buffer-unavailable status bit and waits for a poll strobe before it reads that descriptor again. A second status bit marks each completed frame. Both status bits are cleared by writing a 1 to them.

Top module: `rxdma_top`

## Requirements
- R1: After reset the engine is idle. It makes no memory access, `in_ready_o` is low and both status bits are 0 until `start_i` is seen high. A `poll_i` pulse while idle has no effect.
- R2: On start, the engine latches `list_base_i` as the first descriptor address. It reads descriptor words 0, 1, 2 and 3 in that order, from byte addresses D, D+4, D+8 and D+12.
- R3: If bit 31 (owner) of word 0 is 0, the engine sets `stat_o[1]` (unavailable), accepts no bytes and makes no memory write. A `poll_i` pulse makes it read the same descriptor again.
- R4: Frame byte i is written at byte address B+i, where B is word 2. The write enables only the lane `1 << ((B+i) mod 4)` and carries the byte on that lane.
- R5: Closing writes word 0 with all four byte enables set. In that word, bit 31 = 0, bit 9 = first-segment = 1, bit 8 = last-segment = 1, bits 29:16 = stored byte count, and bit 15 = error summary. The error-summary bit is set when any byte of the frame came with `in_err_i`.
- R6: The buffer size is word 1 bits 12:0. Bytes beyond that size are not written, the stored count equals the size, and the error-summary bit is set. The descriptor is still closed.
- R7: When word 1 bit 24 (chain) is 1, the next descriptor address is word 3. When that bit is 0, the next descriptor address is D+32.
- R8: `stat_o[0]` (frame done) becomes 1 in the cycle the closing write is presented. Each `stat_o` bit is cleared by a 1 on the matching bit of `stat_clr_i`, and a set in the same cycle wins over a clear.
- R9: `in_ready_o` is high only while an engine-owned descriptor is open for a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| list_base_i | input | AW | Byte address of the first descriptor |
| start_i | input | 1 | Leaves idle and starts at the base address |
| poll_i | input | 1 | Poll strobe: retry a software-owned descriptor |
| in_valid_i | input | 1 | Frame byte valid |
| in_data_i | input | 8 | Frame byte |
| in_last_i | input | 1 | Marks the last byte of a frame |
| in_err_i | input | 1 | Byte received with an error |
| in_ready_o | output | 1 | Engine accepts a byte this cycle |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write (1) or read (0) |
| mem_addr_o | output | AW | Byte address |
| mem_be_o | output | 4 | Byte-lane write enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the read is taken |
| stat_clr_i | input | 2 | Write-1-to-clear for the status bits |
| stat_o | output | 2 | Bit 0 frame done, bit 1 buffer unavailable |

## Verification
A corrupted next-descriptor address or buffer offset shows up at the ports within one descriptor. The next read of word 0 comes from the wrong address, or a byte lands on the wrong lane or address, and this can be seen on the very next memory request. A wrong byte count or a lost error flag is exposed in the closing write, which comes one cycle after the last byte. Ownership mistakes show up in the same cycle as a stray `in_ready_o`, or as an unavailable bit that never rises.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FREQ, S_FWAIT, S_FDATA, S_RECV, S_CLOSE, S_SUSP
  } rxdma_state_e;

  localparam int OWN_BIT   = 31;
  localparam int CHAIN_BIT = 24;
  localparam int ES_BIT    = 15;
  localparam int FS_BIT    = 9;
  localparam int LS_BIT    = 8;
  localparam int LEN_LSB   = 16;
  localparam int DESC_BYTES = 32;
endpackage

// File: rtl/rxdma_lanes.sv
module rxdma_lanes #(
  parameter int LANES = 4
) (
  input  logic [$clog2(LANES)-1:0] lane_i,
  input  logic                     whole_i,
  input  logic [7:0]               byte_i,
  input  logic [8*LANES-1:0]       word_i,
  output logic [LANES-1:0]         be_o,
  output logic [8*LANES-1:0]       data_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_o[g]        = whole_i || (lane_i == g);
    assign data_o[8*g +: 8] = whole_i ? word_i[8*g +: 8] : byte_i;
  end
endmodule

// File: rtl/rxdma_status.sv
module rxdma_status #(
  parameter int NBITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] set_i,
  input  logic [NBITS-1:0] clr_i,
  output logic [NBITS-1:0] stat_o
);
  always_ff @(posedge clk) begin
    if (rst) stat_o <= '0;
    else     stat_o <= (stat_o & ~clr_i) | set_i;
  end

  // R8: a clear with no set drops the bit on the next cycle
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_i[0] && !set_i[0]) |=> !stat_o[0]);
endmodule

// File: rtl/rxdma_fsm.sv
module rxdma_fsm
  import rxdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SIZE_W = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] list_base_i,
  input  logic          start_i,
  input  logic          poll_i,
  input  logic          in_valid_i,
  input  logic          in_last_i,
  input  logic          in_err_i,
  input  logic [7:0]    in_data_i,
  output logic          in_ready_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          whole_o,
  output logic [7:0]    byte_o,
  output logic [31:0]   word_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          done_set_o,
  output logic          unav_set_o
);
  localparam int LEN_W = SIZE_W + 1;

  rxdma_state_e state;
  logic [1:0]        idx;
  logic [AW-1:0]     cur_q, nxt_q, buf_q;
  logic [SIZE_W-1:0] size_q;
  logic              chain_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              err_q, trunc_q;
  logic              room;

  assign room       = cnt_q < LEN_W'(size_q);
  assign in_ready_o = (state == S_RECV);
  assign done_set_o = (state == S_CLOSE);
  assign unav_set_o = (state == S_FDATA) && (idx == 2'd0) && !mem_rdata_i[OWN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; idx <= '0;
      cur_q <= '0; nxt_q <= '0; buf_q <= '0; size_q <= '0; chain_q <= 1'b0;
      cnt_q <= '0; err_q <= 1'b0; trunc_q <= 1'b0;
      mem_en_o <= 1'b0; mem_we_o <= 1'b0; mem_addr_o <= '0;
      whole_o <= 1'b0; byte_o <= '0; word_o <= '0;
    end else begin
      mem_en_o <= 1'b0;
      mem_we_o <= 1'b0;
      unique case (state)
        S_IDLE: if (start_i) begin
          cur_q <= list_base_i;
          idx   <= '0;
          state <= S_FREQ;
        end
        S_FREQ: begin
          mem_en_o   <= 1'b1;
          mem_addr_o <= cur_q + AW'({idx, 2'b00});
          state      <= S_FWAIT;
        end
        S_FWAIT: state <= S_FDATA;
        S_FDATA: begin
          state <= S_FREQ;
          idx   <= idx + 2'd1;
          unique case (idx)
            2'd0: if (!mem_rdata_i[OWN_BIT]) begin
              state <= S_SUSP;
              idx   <= '0;
            end
            2'd1: begin
              size_q  <= mem_rdata_i[SIZE_W-1:0];
              chain_q <= mem_rdata_i[CHAIN_BIT];
            end
            2'd2: buf_q <= mem_rdata_i[AW-1:0];
            default: begin
              nxt_q   <= chain_q ? mem_rdata_i[AW-1:0] : cur_q + AW'(DESC_BYTES);
              cnt_q   <= '0;
              err_q   <= 1'b0;
              trunc_q <= 1'b0;
              state   <= S_RECV;
            end
          endcase
        end
        S_RECV: if (in_valid_i) begin
          if (room) begin
            mem_en_o   <= 1'b1;
            mem_we_o   <= 1'b1;
            whole_o    <= 1'b0;
            byte_o     <= in_data_i;
            mem_addr_o <= buf_q + AW'(cnt_q);
            cnt_q      <= cnt_q + 1'b1;
          end else begin
            trunc_q <= 1'b1;
          end
          err_q <= err_q | in_err_i;
          if (in_last_i) state <= S_CLOSE;
        end
        S_CLOSE: begin
          mem_en_o   <= 1'b1;
          mem_we_o   <= 1'b1;
          whole_o    <= 1'b1;
          mem_addr_o <= cur_q;
          word_o     <= '0;
          word_o[LEN_LSB +: LEN_W] <= cnt_q;
          word_o[ES_BIT] <= err_q | trunc_q;
          word_o[FS_BIT] <= 1'b1;
          word_o[LS_BIT] <= 1'b1;
          cur_q <= nxt_q;
          idx   <= '0;
          state <= S_FREQ;
        end
        S_SUSP: if (poll_i) begin
          idx   <= '0;
          state <= S_FREQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: no memory traffic while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !mem_en_o);
  // R3: a suspended engine neither writes nor takes bytes
  a_r3_susp_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == S_SUSP) |-> (!mem_we_o && !in_ready_o));
  // R6: a byte arriving with the buffer full produces no write
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (in_ready_o && in_valid_i && !room) |=> !mem_we_o);
  // R5: closing presents a full-word write with the owner bit cleared
  a_r5_close_word: assert property (@(posedge clk) disable iff (rst)
    (state == S_CLOSE) |=> (mem_we_o && whole_o && !word_o[OWN_BIT]));
endmodule

// File: rtl/rxdma_top.sv
module rxdma_top #(
  parameter int AW     = 32,
  parameter int SIZE_W = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] list_base_i,
  input  logic          start_i,
  input  logic          poll_i,
  input  logic          in_valid_i,
  input  logic [7:0]    in_data_i,
  input  logic          in_last_i,
  input  logic          in_err_i,
  output logic          in_ready_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_be_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic [1:0]    stat_clr_i,
  output logic [1:0]    stat_o
);
  logic        whole;
  logic [7:0]  wbyte;
  logic [31:0] wword;
  logic        done_set, unav_set;

  rxdma_fsm #(.AW(AW), .SIZE_W(SIZE_W)) u_fsm (
    .clk(clk), .rst(rst), .list_base_i(list_base_i), .start_i(start_i),
    .poll_i(poll_i), .in_valid_i(in_valid_i), .in_last_i(in_last_i),
    .in_err_i(in_err_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .whole_o(whole), .byte_o(wbyte), .word_o(wword), .mem_rdata_i(mem_rdata_i),
    .done_set_o(done_set), .unav_set_o(unav_set)
  );

  rxdma_lanes #(.LANES(4)) u_lanes (
    .lane_i(mem_addr_o[1:0]), .whole_i(whole), .byte_i(wbyte),
    .word_i(wword), .be_o(mem_be_o), .data_o(mem_wdata_o)
  );

  rxdma_status #(.NBITS(2)) u_stat (
    .clk(clk), .rst(rst), .set_i({unav_set, done_set}),
    .clr_i(stat_clr_i), .stat_o(stat_o)
  );

  // R8: frame-done rises together with the closing status-word write
  a_r8_done_with_close: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_o[0]) |-> (mem_we_o && mem_be_o == 4'hF && !mem_wdata_o[31]));
  // R4: a byte write enables exactly one lane
  a_r4_one_lane: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && mem_be_o != 4'hF) |-> ($countones(mem_be_o) == 1));
endmodule

// File: tb/rxdma_top_tb.sv
module rxdma_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] list_base_i = '0;
  logic start_i = 0, poll_i = 0, in_valid_i = 0, in_last_i = 0, in_err_i = 0;
  logic [7:0] in_data_i = '0;
  logic [1:0] stat_clr_i = '0;
  logic in_ready_o, mem_en_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0] mem_be_o;
  logic [1:0] stat_o;

  rxdma_top u_dut (.*);

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_en_o) begin
      if (mem_we_o) begin
        for (int l = 0; l < 4; l++)
          if (mem_be_o[l]) mem[mem_addr_o[9:2]][8*l +: 8] <= mem_wdata_o[8*l +: 8];
      end else mem_rdata_i <= mem[mem_addr_o[9:2]];
    end
  end

  int nrd = 0, nwr = 0, nrdy = 0;
  logic [31:0] rdlog [0:7];
  always @(posedge clk) begin
    if (!rst && mem_en_o && !mem_we_o) begin
      if (nrd < 8) rdlog[nrd] = mem_addr_o;
      nrd++;
    end
    if (!rst && mem_en_o && mem_we_o) nwr++;
    if (!rst && in_ready_o) nrdy++;
  end

  int checks = 0, failures = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input int a);
    return mem[a[9:2]][8*a[1:0] +: 8];
  endfunction

  task automatic send(input int n, input int seed, input bit err_at_end);
    for (int i = 0; i < n; i++) begin
      forever begin
        @(negedge clk);
        in_valid_i = 1; in_data_i = 8'(seed + i);
        in_last_i = (i == n - 1); in_err_i = err_at_end && (i == n - 1);
        if (in_ready_o) begin @(posedge clk); break; end
      end
    end
    @(negedge clk);
    in_valid_i = 0; in_last_i = 0; in_err_i = 0;
  endtask

  task automatic wait_stat(input int b);
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (stat_o[b]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic clr(input logic [1:0] m);
    @(negedge clk); stat_clr_i = m;
    @(negedge clk); stat_clr_i = '0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); poll_i = 1; @(negedge clk); poll_i = 0;
    repeat (5) @(negedge clk);
    chk("R1 ready", in_ready_o, 0);
    chk("R1 stat", stat_o, 0);
    chk("R1 no access", nrd + nwr, 0);
  endtask

  task automatic t_first_frame;
    list_base_i = 32'h0;
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
    send(6, 8'h10, 0);
    wait_stat(0);
    chk("R2 rd0", rdlog[0], 32'h0);
    chk("R2 rd1", rdlog[1], 32'h4);
    chk("R2 rd2", rdlog[2], 32'h8);
    chk("R2 rd3", rdlog[3], 32'hC);
    for (int i = 0; i < 6; i++) chk("R4 byte", mbyte(32'h201 + i), 8'(8'h10 + i));
    chk("R4 untouched lane", mbyte(32'h200), 8'hEE);
    chk("R5 word0", mem[0], 32'h0006_0300);
    chk("R8 done set", stat_o[0], 1);
    clr(2'b01);
    chk("R8 done cleared", stat_o[0], 0);
  endtask

  task automatic t_truncate;
    send(7, 8'h40, 0);
    wait_stat(0);
    chk("R7 chained fetch", rdlog[4], 32'h40);
    chk("R6 word0", mem[32'h40 >> 2], 32'h0004_8300);
    chk("R6 last kept", mbyte(32'h283), 8'h43);
    chk("R6 not written", mbyte(32'h284), 8'hEE);
    clr(2'b01);
  endtask

  task automatic t_error_then_unavail;
    int wr0, rd0;
    send(3, 8'h70, 1);
    wait_stat(1);
    chk("R5 err word0", mem[32'h60 >> 2], 32'h0003_8300);
    chk("R7 sequential addr", mbyte(32'h300), 8'h70);
    chk("R3 unavail", stat_o[1], 1);
    wr0 = nwr; rd0 = nrd;
    @(negedge clk); in_valid_i = 1; in_data_i = 8'h99; in_last_i = 1;
    repeat (10) @(negedge clk);
    chk("R9 ready low", in_ready_o, 0);
    in_valid_i = 0; in_last_i = 0;
    chk("R3 no write", nwr - wr0, 0);
    chk("R3 no refetch", nrd - rd0, 0);
    mem[0] = 32'h8000_0000;
    clr(2'b10);
    chk("R8 unav cleared", stat_o[1], 0);
    @(negedge clk); poll_i = 1; @(negedge clk); poll_i = 0;
    send(2, 8'hA0, 0);
    wait_stat(0);
    chk("R3 resumed word0", mem[0], 32'h0002_0300);
    chk("R3 resumed data", mbyte(32'h201), 8'hA0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hEEEE_EEEE;
    mem[0] = 32'h8000_0000; mem[1] = 32'h0100_0040; mem[2] = 32'h201; mem[3] = 32'h40;
    mem[16] = 32'h8000_0000; mem[17] = 32'h0000_0004; mem[18] = 32'h280; mem[19] = 32'h0;
    mem[24] = 32'h8000_0000; mem[25] = 32'h0100_0020; mem[26] = 32'h300; mem[27] = 32'h0;
    t_reset;
    t_first_frame;
    t_truncate;
    t_error_then_unavail;
    chk("R9 ready count", (nrdy > 0), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule